// File: doc/BRIEF.md
# Barrel Multithreaded Issue Scheduler

This block sits at the front of a fine-grained multithreaded processor. In every cycle it chooses one hardware thread out of a large pool of contexts and names that thread as the source of the instruction word issued in that cycle. Moving from one thread to another costs no cycles. Each thread context keeps two pieces of readiness state. The first is a re-issue spacing timer, which keeps a thread from issuing again within a fixed number of cycles. The second is a small table of outstanding memory references.

When a memory instruction issues, the block places its reference in the lowest free slot of the thread's table and reports that slot as the reference ID. The instruction's 3-bit lookahead value N sets an allowance: the thread may issue N more instructions while the reference is still in flight. Each later issue from the same thread lowers the allowance of every reference that is still pending. A reference whose allowance has reached zero holds the thread back until the memory system sends a completion pulse tagged with that thread and reference ID. When several threads are eligible, they are served round-robin, starting from the thread after the one that issued last.

Each thread is classified every cycle into one of four named states:
- TS_SPACING: the thread's timer is non-zero.
- TS_IDLE: the timer is zero, but the thread has no instruction available.
- TS_MEMWAIT: the timer is zero and an instruction is available, but a reference with zero allowance is pending, or the reference table is full while the head instruction is a memory instruction.
- TS_ELIGIBLE: none of the above applies.

The state transitions are:
- TS_ELIGIBLE goes to TS_SPACING when the thread issues.
- TS_SPACING goes to one of the other three states when the timer reaches zero.
- TS_MEMWAIT goes to TS_ELIGIBLE in the cycle after the blocking reference completes.
- TS_IDLE goes to TS_ELIGIBLE when the thread's available flag rises.

Top module: `barrel_issue_sched`

## Requirements
- R1: After reset no thread has a pending reference and all spacing timers are zero. While no thread flags an available instruction, `iss_valid_o` is low. The first search after reset starts at thread 0.
- R2: The same thread never issues in two consecutive cycles.
- R3: A thread that issues in cycle t cannot issue again before cycle t+MIN_GAP. A thread that is alone in the pool and always available issues exactly every MIN_GAP cycles.
- R4: Among the eligible threads, the one chosen is the first in ascending index order (wrapping past the highest index) after the thread that issued last.
- R5: A memory instruction with lookahead N lets the thread issue exactly N further instructions while its reference is outstanding. The thread then stalls until the completion arrives, and becomes eligible in the cycle after the completion.
- R6: A completion clears only the reference whose thread ID and reference ID both match. A completion for another thread, or for a reference ID that is not pending, changes nothing.
- R7: When a memory instruction issues (`iss_mem_o` = 1), `iss_rid_o` gives the lowest-numbered reference slot of that thread that was free before the cycle. When a non-memory instruction issues, `iss_rid_o` is 0.
- R8: When a completion and an issue of the same thread fall in the same cycle, the following all hold. The completed reference is cleared and does not lose allowance. The other pending references of the thread each lose one allowance. A new reference is placed using the slot occupancy from before the completion.
- R9: In a cycle with no eligible thread, `iss_valid_o` is low. The round-robin position and all reference tables keep their values, and only the spacing timers count down.
- R10: A thread whose available flag is low is never issued, even when its timer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready_i | input | NUM_THREADS | Per-thread flag: an instruction word is available |
| head_mem_i | input | NUM_THREADS | Per-thread flag: the next instruction is a memory reference |
| head_la_i | input | NUM_THREADS*LA_W | Lookahead of each thread's next instruction; thread t uses bits [t*LA_W +: LA_W] |
| cmp_valid_i | input | 1 | Memory completion pulse |
| cmp_tid_i | input | TID_W | Thread ID carried by the completion |
| cmp_rid_i | input | RID_W | Reference ID carried by the completion |
| iss_valid_o | output | 1 | An instruction issues in this cycle |
| iss_tid_o | output | TID_W | Issuing thread |
| iss_mem_o | output | 1 | The issued instruction is a memory reference |
| iss_rid_o | output | RID_W | Reference slot given to the issued memory instruction |

## Verification
The delicate overlap is a memory completion that arrives in the same cycle as an issue from the same thread. The bench sets this up by issuing a memory instruction with lookahead 1 and keeping the thread alone in the pool, so that its next issue falls exactly MIN_GAP cycles later. It then drives the completion for the first reference in that very cycle, while a second memory instruction issues. The result is judged at the ports in three ways. The second reference must be reported as slot 1, because slot 0 was still occupied when the slot was chosen. The following issue must come MIN_GAP cycles later, which shows that the cleared reference did not block. The issue after that must stall until slot 1 completes.

// File: rtl/barrel_pkg.sv
package barrel_pkg;

    // Per-thread readiness classification, evaluated every cycle
    typedef enum logic [1:0] {
        TS_IDLE     = 2'd0,
        TS_SPACING  = 2'd1,
        TS_MEMWAIT  = 2'd2,
        TS_ELIGIBLE = 2'd3
    } thr_state_e;

endpackage

// File: rtl/barrel_thread_ctx.sv
module barrel_thread_ctx
    import barrel_pkg::*;
#(
    parameter int MIN_GAP = 20,
    parameter int NREF    = 8,
    parameter int LA_W    = 3,
    localparam int RID_W  = (NREF > 1) ? $clog2(NREF) : 1,
    localparam int TMR_W  = $clog2(MIN_GAP),
    localparam int SIN_W  = $clog2(MIN_GAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ready_i,
    input  logic             head_mem_i,
    input  logic [LA_W-1:0]  head_la_i,
    input  logic             issue_i,
    input  logic             cmp_hit_i,
    input  logic [RID_W-1:0] cmp_rid_i,
    output thr_state_e       state_o,
    output logic [RID_W-1:0] alloc_rid_o
);

    logic [TMR_W-1:0] gap_tmr;
    logic [NREF-1:0]  ref_vld;
    logic [LA_W-1:0]  ref_allow [NREF];
    logic             stall_ref;
    logic             tbl_full;
    logic             alloc_found;

    // Reference table scan: blocking entry, free slot search
    always_comb begin
        stall_ref   = 1'b0;
        tbl_full    = 1'b1;
        alloc_found = 1'b0;
        alloc_rid_o = '0;
        for (int s = 0; s < NREF; s++) begin
            if (ref_vld[s] && (ref_allow[s] == '0)) begin
                stall_ref = 1'b1;
            end
            if (!ref_vld[s]) begin
                tbl_full = 1'b0;
                if (!alloc_found) begin
                    alloc_found = 1'b1;
                    alloc_rid_o = RID_W'(s);
                end
            end
        end
    end

    // Readiness classification
    always_comb begin
        if (gap_tmr != '0) begin
            state_o = TS_SPACING;
        end else if (!ready_i) begin
            state_o = TS_IDLE;
        end else if (stall_ref || (head_mem_i && tbl_full)) begin
            state_o = TS_MEMWAIT;
        end else begin
            state_o = TS_ELIGIBLE;
        end
    end

    // Re-issue spacing timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_tmr <= '0;
        end else if (issue_i) begin
            gap_tmr <= TMR_W'(MIN_GAP - 1);
        end else if (gap_tmr != '0) begin
            gap_tmr <= gap_tmr - 1'b1;
        end
    end

    // Outstanding reference slots
    for (genvar s = 0; s < NREF; s++) begin : g_slot
        logic clr_hit;
        logic new_ref;
        assign clr_hit = cmp_hit_i && (cmp_rid_i == RID_W'(s));
        assign new_ref = issue_i && head_mem_i && !tbl_full && (alloc_rid_o == RID_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_vld[s]   <= 1'b0;
                ref_allow[s] <= '0;
            end else if (new_ref) begin
                ref_vld[s]   <= 1'b1;
                ref_allow[s] <= head_la_i;
            end else if (clr_hit) begin
                ref_vld[s]   <= 1'b0;
            end else if (issue_i && ref_vld[s] && (ref_allow[s] != '0)) begin
                ref_allow[s] <= ref_allow[s] - 1'b1;
            end
        end
    end

    // Checker state: cycles since this thread last issued
    logic [SIN_W-1:0] since_cnt;
    logic             ever_issued;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_cnt   <= '0;
            ever_issued <= 1'b0;
        end else if (issue_i) begin
            since_cnt   <= '0;
            ever_issued <= 1'b1;
        end else if (since_cnt != SIN_W'(MIN_GAP)) begin
            since_cnt <= since_cnt + 1'b1;
        end
    end

    // R3: re-issue only once the spacing window has elapsed
    a_r3_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && ever_issued) |-> (since_cnt >= SIN_W'(MIN_GAP - 1)));

    // R5: no issue while a reference with exhausted allowance is pending
    a_r5_lookahead_block: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> !stall_ref);

    // R7: a memory issue always finds a free slot
    a_r7_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && head_mem_i) |-> !tbl_full);

endmodule

// File: rtl/barrel_rr_pick.sv
module barrel_rr_pick #(
    parameter int N = 128,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     elig_i,
    input  logic [IDX_W-1:0] last_i,
    output logic             any_o,
    output logic [IDX_W-1:0] pick_o
);

    // Scan starting one past the last winner, wrapping around
    always_comb begin
        int p;
        any_o  = 1'b0;
        pick_o = '0;
        p      = 0;
        for (int off = 1; off <= N; off++) begin
            p = (int'(last_i) + off) % N;
            if (!any_o && elig_i[p[IDX_W-1:0]]) begin
                any_o  = 1'b1;
                pick_o = p[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/barrel_issue_sched.sv
module barrel_issue_sched
    import barrel_pkg::*;
#(
    parameter int NUM_THREADS = 128,
    parameter int MIN_GAP     = 20,
    parameter int NREF        = 8,
    parameter int LA_W        = 3,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int RID_W      = (NREF > 1) ? $clog2(NREF) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_THREADS-1:0]      thr_ready_i,
    input  logic [NUM_THREADS-1:0]      head_mem_i,
    input  logic [NUM_THREADS*LA_W-1:0] head_la_i,
    input  logic                        cmp_valid_i,
    input  logic [TID_W-1:0]            cmp_tid_i,
    input  logic [RID_W-1:0]            cmp_rid_i,
    output logic                        iss_valid_o,
    output logic [TID_W-1:0]            iss_tid_o,
    output logic                        iss_mem_o,
    output logic [RID_W-1:0]            iss_rid_o
);

    thr_state_e             thr_state [NUM_THREADS];
    logic [RID_W-1:0]       thr_alloc [NUM_THREADS];
    logic [NUM_THREADS-1:0] thr_elig;
    logic [NUM_THREADS-1:0] thr_issue;
    logic [TID_W-1:0]       last_tid;
    logic                   pick_any;
    logic [TID_W-1:0]       pick_tid;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        barrel_thread_ctx #(
            .MIN_GAP (MIN_GAP),
            .NREF    (NREF),
            .LA_W    (LA_W)
        ) ctx_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .ready_i     (thr_ready_i[t]),
            .head_mem_i  (head_mem_i[t]),
            .head_la_i   (head_la_i[t*LA_W +: LA_W]),
            .issue_i     (thr_issue[t]),
            .cmp_hit_i   (cmp_valid_i && (cmp_tid_i == TID_W'(t))),
            .cmp_rid_i   (cmp_rid_i),
            .state_o     (thr_state[t]),
            .alloc_rid_o (thr_alloc[t])
        );

        always_comb begin
            unique case (thr_state[t])
                TS_ELIGIBLE: thr_elig[t] = 1'b1;
                TS_IDLE,
                TS_SPACING,
                TS_MEMWAIT:  thr_elig[t] = 1'b0;
                default:     thr_elig[t] = 1'b0;
            endcase
        end

        assign thr_issue[t] = pick_any && (pick_tid == TID_W'(t));
    end

    barrel_rr_pick #(
        .N (NUM_THREADS)
    ) pick_i (
        .elig_i (thr_elig),
        .last_i (last_tid),
        .any_o  (pick_any),
        .pick_o (pick_tid)
    );

    // Round-robin position: moves only on an issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_tid <= TID_W'(NUM_THREADS - 1);
        end else if (pick_any) begin
            last_tid <= pick_tid;
        end
    end

    // Issue outputs
    always_comb begin
        iss_valid_o = pick_any;
        iss_tid_o   = pick_tid;
        iss_mem_o   = pick_any && head_mem_i[pick_tid];
        iss_rid_o   = iss_mem_o ? thr_alloc[pick_tid] : '0;
    end

    // Checker state: previous cycle's issue
    logic             prev_vld;
    logic [TID_W-1:0] prev_tid;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_vld <= 1'b0;
            prev_tid <= '0;
        end else begin
            prev_vld <= iss_valid_o;
            prev_tid <= iss_tid_o;
        end
    end

    // R2: no back-to-back issue of one thread
    a_r2_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_o && prev_vld) |-> (iss_tid_o != prev_tid));

    // R10: only threads with an available instruction issue
    a_r10_ready_only: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |-> thr_ready_i[iss_tid_o]);

    // R4: the chosen thread is one that its context reports eligible
    a_r4_pick_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid_o |-> (thr_state[iss_tid_o] == TS_ELIGIBLE));

    // R9: no issue when nobody is eligible
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_elig == '0) |-> !iss_valid_o);

endmodule

// File: tb/barrel_issue_sched_tb.sv
module barrel_issue_sched_tb_top;

    localparam int NT    = 8;
    localparam int GAP   = 20;
    localparam int NREF  = 8;
    localparam int LA_W  = 3;
    localparam int TID_W = 3;
    localparam int RID_W = 3;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NT-1:0]        thr_ready;
    logic [NT-1:0]        head_mem;
    logic [NT*LA_W-1:0]   head_la;
    logic                 cmp_valid;
    logic [TID_W-1:0]     cmp_tid;
    logic [RID_W-1:0]     cmp_rid;
    logic                 iss_valid;
    logic [TID_W-1:0]     iss_tid;
    logic                 iss_mem;
    logic [RID_W-1:0]     iss_rid;

    int checks   = 0;
    int failures = 0;
    int gcyc     = 0;
    int last_seen = NT - 1;
    logic             s_vld;
    logic [TID_W-1:0] s_tid;
    logic             s_mem;
    logic [RID_W-1:0] s_rid;

    always #2 clk = ~clk;

    barrel_issue_sched #(
        .NUM_THREADS (NT),
        .MIN_GAP     (GAP),
        .NREF        (NREF),
        .LA_W        (LA_W)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .thr_ready_i (thr_ready),
        .head_mem_i  (head_mem),
        .head_la_i   (head_la),
        .cmp_valid_i (cmp_valid),
        .cmp_tid_i   (cmp_tid),
        .cmp_rid_i   (cmp_rid),
        .iss_valid_o (iss_valid),
        .iss_tid_o   (iss_tid),
        .iss_mem_o   (iss_mem),
        .iss_rid_o   (iss_rid)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Go to the next falling edge; inputs may be changed before obs()
    task automatic nxt();
        @(negedge clk);
    endtask

    // Settle and sample the outputs for the coming rising edge
    task automatic obs();
        #1;
        s_vld = iss_valid;
        s_tid = iss_tid;
        s_mem = iss_mem;
        s_rid = iss_rid;
        gcyc++;
        if (s_vld) last_seen = int'(s_tid);
    endtask

    task automatic cyc();
        nxt();
        obs();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wait_issue(input int maxc, output bit got);
        got = 1'b0;
        for (int i = 0; i < maxc && !got; i++) begin
            cyc();
            if (s_vld) got = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        thr_ready = '0;
        head_mem = '0;
        head_la = '0;
        cmp_valid = 1'b0;
        cmp_tid = '0;
        cmp_rid = '0;
        idle(5);
        nxt();
        rst_n = 1'b1;
        obs();
        check(!s_vld, "R1 valid low after reset", int'(s_vld), 0);
        idle(3);
        check(!s_vld, "R1 valid low with no ready thread", int'(s_vld), 0);
    endtask

    // R4, R10, R2, R1: all but thread 5 ready
    task automatic t_round_robin();
        int tids [8];
        int cycs [8];
        int n = 0;
        int exp_seq [7] = '{0, 1, 2, 3, 4, 6, 7};
        bit saw5 = 1'b0;
        bit rep = 1'b0;
        int prev_c = -10;
        int prev_t = -1;
        nxt();
        thr_ready = 8'hFF & ~8'h20;
        obs();
        for (int i = 0; i < 60 && n < 8; i++) begin
            if (i > 0) cyc();
            if (s_vld) begin
                if (int'(s_tid) == 5) saw5 = 1'b1;
                if (prev_c == gcyc - 1 && prev_t == int'(s_tid)) rep = 1'b1;
                prev_c = gcyc;
                prev_t = int'(s_tid);
                tids[n] = int'(s_tid);
                cycs[n] = gcyc;
                n++;
            end
        end
        nxt();
        thr_ready = '0;
        obs();
        check(n == 8, "R4 eight issues seen", n, 8);
        check(tids[0] == 0, "R1 first pick after reset is thread 0", tids[0], 0);
        for (int k = 1; k < 7; k++) begin
            check(tids[k] == exp_seq[k], "R4 round-robin order", tids[k], exp_seq[k]);
            check(cycs[k] == cycs[0] + k, "R4 issues in consecutive cycles", cycs[k] - cycs[0], k);
        end
        check(!saw5, "R10 unavailable thread 5 never issued", int'(saw5), 0);
        check(!rep, "R2 no back-to-back same thread", int'(rep), 0);
        check(tids[7] == 0, "R3 thread 0 returns first", tids[7], 0);
        check(cycs[7] - cycs[0] == GAP, "R3 gap for thread 0", cycs[7] - cycs[0], GAP);
        idle(25);
    endtask

    // R3: a lone thread issues exactly every GAP cycles
    task automatic t_single_gap();
        int c [3];
        bit got;
        nxt();
        thr_ready = 8'h08;
        obs();
        if (s_vld) got = 1'b1; else wait_issue(40, got);
        c[0] = gcyc;
        for (int k = 1; k < 3; k++) begin
            wait_issue(40, got);
            c[k] = gcyc;
            check(got && s_tid == 3, "R3 lone thread reissues", int'(s_tid), 3);
            check(c[k] - c[k-1] == GAP, "R3 exact spacing", c[k] - c[k-1], GAP);
        end
        nxt();
        thr_ready = '0;
        obs();
        idle(25);
    endtask

    // R5, R6, R7: lookahead 0 on thread 2
    task automatic t_la_zero();
        bit got;
        int cnt = 0;
        nxt();
        thr_ready = 8'h04;
        head_mem[2] = 1'b1;
        head_la[2*LA_W +: LA_W] = 3'd0;
        obs();
        if (!s_vld) wait_issue(40, got);
        check(s_vld && s_tid == 2 && s_mem, "R7 memory issue flagged", int'(s_mem), 1);
        check(s_rid == 0, "R7 first reference in slot 0", int'(s_rid), 0);
        nxt();
        head_mem[2] = 1'b0;
        obs();
        for (int i = 0; i < 40; i++) begin cyc(); if (s_vld) cnt++; end
        check(cnt == 0, "R5 lookahead 0 stalls next instruction", cnt, 0);
        nxt();
        cmp_valid = 1'b1; cmp_tid = 3'd5; cmp_rid = 3'd0;
        obs();
        nxt();
        cmp_tid = 3'd2; cmp_rid = 3'd1;
        obs();
        nxt();
        cmp_valid = 1'b0;
        obs();
        cnt = 0;
        for (int i = 0; i < 10; i++) begin cyc(); if (s_vld) cnt++; end
        check(cnt == 0, "R6 unmatched completions ignored", cnt, 0);
        nxt();
        cmp_valid = 1'b1; cmp_tid = 3'd2; cmp_rid = 3'd0;
        obs();
        check(!s_vld, "R5 no issue in completion cycle", int'(s_vld), 0);
        nxt();
        cmp_valid = 1'b0;
        obs();
        check(s_vld && s_tid == 2, "R5 eligible the cycle after completion", int'(s_vld), 1);
        nxt();
        thr_ready = '0;
        obs();
        idle(25);
    endtask

    // R5: lookahead 2 on thread 6 allows exactly two more issues
    task automatic t_la_two();
        bit got;
        int cnt = 0;
        nxt();
        thr_ready = 8'h40;
        head_mem[6] = 1'b1;
        head_la[6*LA_W +: LA_W] = 3'd2;
        obs();
        if (!s_vld) wait_issue(40, got);
        check(s_vld && s_rid == 0, "R7 slot 0 reused after clear", int'(s_rid), 0);
        nxt();
        head_mem[6] = 1'b0;
        obs();
        for (int i = 0; i < 100; i++) begin cyc(); if (s_vld) cnt++; end
        check(cnt == 2, "R5 lookahead 2 allows two issues", cnt, 2);
        nxt();
        cmp_valid = 1'b1; cmp_tid = 3'd6; cmp_rid = 3'd0;
        obs();
        nxt();
        cmp_valid = 1'b0;
        obs();
        check(s_vld && s_tid == 6, "R5 resumes after completion", int'(s_vld), 1);
        nxt();
        thr_ready = '0;
        obs();
        idle(25);
    endtask

    // R8: completion and issue of thread 4 in the same cycle
    task automatic t_same_cycle();
        bit got;
        int c0;
        int cnt = 0;
        nxt();
        thr_ready = 8'h10;
        head_mem[4] = 1'b1;
        head_la[4*LA_W +: LA_W] = 3'd1;
        obs();
        if (!s_vld) wait_issue(40, got);
        check(s_vld && s_tid == 4 && s_rid == 0, "R8 first reference slot 0", int'(s_rid), 0);
        idle(GAP - 1);
        nxt();
        cmp_valid = 1'b1; cmp_tid = 3'd4; cmp_rid = 3'd0;
        obs();
        c0 = gcyc;
        check(s_vld && s_tid == 4, "R8 second issue in completion cycle", int'(s_vld), 1);
        check(s_rid == 1, "R8 allocation sees slot 0 still occupied", int'(s_rid), 1);
        nxt();
        cmp_valid = 1'b0;
        head_mem[4] = 1'b0;
        obs();
        wait_issue(40, got);
        check(got && s_tid == 4, "R8 cleared reference does not block", int'(got), 1);
        check(gcyc - c0 == GAP, "R8 next issue after one gap", gcyc - c0, GAP);
        for (int i = 0; i < 40; i++) begin cyc(); if (s_vld) cnt++; end
        check(cnt == 0, "R8 remaining reference lost allowance", cnt, 0);
        nxt();
        cmp_valid = 1'b1; cmp_tid = 3'd4; cmp_rid = 3'd1;
        obs();
        nxt();
        cmp_valid = 1'b0;
        obs();
        check(s_vld && s_tid == 4, "R5 slot 1 completion releases thread", int'(s_vld), 1);
        nxt();
        thr_ready = '0;
        obs();
        idle(25);
    endtask

    // R9: idle cycles leave the round-robin position untouched
    task automatic t_idle_ptr();
        int cnt = 0;
        int l;
        int a;
        int b;
        for (int i = 0; i < 25; i++) begin cyc(); if (s_vld) cnt++; end
        check(cnt == 0, "R9 valid low with nothing eligible", cnt, 0);
        l = last_seen;
        a = (l + 3) % NT;
        b = (l + 6) % NT;
        nxt();
        thr_ready = '0;
        thr_ready[a] = 1'b1;
        thr_ready[b] = 1'b1;
        obs();
        check(s_vld && int'(s_tid) == a, "R9 search resumes after last issuer", int'(s_tid), a);
        cyc();
        check(s_vld && int'(s_tid) == b, "R4 second ready thread next", int'(s_tid), b);
        nxt();
        thr_ready = '0;
        obs();
    endtask

    initial begin
        #(4 * 190000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", gcyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_round_robin();
        t_single_gap();
        t_la_zero();
        t_la_two();
        t_same_cycle();
        t_idle_ptr();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule